// File: doc/BRIEF.md
# I2C Target Address-Phase Receiver

This block is the addressing front end of an I2C target. It samples the raw SCL and SDA lines with the system clock and finds bus START and STOP conditions. After each START it shifts in the address byte, or the two address bytes, and compares them with a configured own address. When they match, it pulls SDA low for the acknowledge bit and reports whether the controller wants to read or to write.

A mode input selects 7-bit or 10-bit addressing. In 10-bit mode the first byte carries a fixed prefix, the two upper address bits and the direction bit. The second byte carries the eight lower address bits. The block acknowledges each byte that matches its part of the address. It pulses the match output only once the whole address has matched. After a mismatch it lets go of the bus until the next START or STOP. The data phase that follows the address is handled elsewhere. The system clock must run several times faster than SCL.

Top module: `i2c_tgt_addr`

## Requirements
- R1: A falling SDA while SCL is high is a START. `start_o` pulses high for one cycle, and address reception begins again from the first byte.
- R2: A rising SDA while SCL is high is a STOP. `stop_o` pulses high for one cycle, `sda_pull_o` is released in that same cycle, and the block goes idle.
- R3: An address bit is taken at each rising SCL edge, and the most significant bit comes first.
- R4: In 7-bit mode (`mode10_i` = 0), bits 7:1 of the first byte are compared with `own_addr_i[6:0]`. Bit 0 gives the direction: 1 means read and 0 means write.
- R5: The acknowledge pull-down `sda_pull_o` is raised after the SCL falling edge that ends the eighth bit. It is dropped after the next SCL falling edge, and it changes only while SCL is low.
- R6: In 10-bit mode (`mode10_i` = 1), the first byte is acknowledged when its bits 7:3 equal 11110 and its bits 2:1 equal `own_addr_i[9:8]`. That byte alone gives no match pulse.
- R7: In 10-bit mode, the second byte is acknowledged when it equals `own_addr_i[7:0]`. `match_o` then pulses, and the direction is taken from bit 0 of the first byte.
- R8: A byte that does not match gets no acknowledge. All later bytes are ignored until the next START or STOP.
- R9: A repeated START, even in the middle of a byte, drops the partial byte and restarts address reception.
- R10: In 10-bit mode, a first byte without the 11110 prefix is ignored. In 7-bit mode, a byte with that prefix is compared as an ordinary 7-bit address.
- R11: `match_o` is a one-cycle pulse that comes in the same cycle as the rise of `sda_pull_o`. `rd_o` changes only together with a match pulse and otherwise keeps its value.
- R12: While reset is active, `sda_pull_o`, `match_o`, `rd_o`, `start_o` and `stop_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, several times faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line |
| sda_i | input | 1 | Raw SDA line, as seen on the wired bus |
| own_addr_i | input | 10 | Own address; in 7-bit mode only bits 6:0 are used |
| mode10_i | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit |
| sda_pull_o | output | 1 | Drives SDA low when high (acknowledge) |
| match_o | output | 1 | One-cycle pulse when the full address has matched |
| rd_o | output | 1 | Direction of the last matched transfer, 1 = read |
| start_o | output | 1 | One-cycle pulse on a START |
| stop_o | output | 1 | One-cycle pulse on a STOP |

## Verification
The hardest cases to reach are a repeated START that cuts into a half-sent byte, and a second byte sent without a new START after a mismatch. The bench drives the bus as a bit-level controller and has full control of SCL and SDA between bits. It can therefore stop partway through a byte and issue a START, or keep clocking a byte that would otherwise match and check that no acknowledge comes. In the 10-bit cases the bench gets past the first byte's acknowledge and then makes the second byte mismatch. This separates the per-byte acknowledge from the match pulse.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned MARK_W = 5;
  localparam logic [MARK_W-1:0] TEN_BIT_MARK = 5'b11110;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BYTE,
    ST_ACK,
    ST_SKIP
  } addr_st_e;
endpackage

// File: rtl/i2c_sync.sv
module i2c_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    // idle bus level is high
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_det_o,
  output logic stop_det_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      scl_q   <= scl_s_i;
      sda_q   <= sda_s_i;
      start_o <= start_det_o;
      stop_o  <= stop_det_o;
    end
  end

  assign start_det_o = scl_q & scl_s_i &  sda_q & ~sda_s_i;
  assign stop_det_o  = scl_q & scl_s_i & ~sda_q &  sda_s_i;
  assign scl_rise_o  = ~scl_q &  scl_s_i;
  assign scl_fall_o  =  scl_q & ~scl_s_i;
endmodule

// File: rtl/i2c_addr_fsm.sv
module i2c_addr_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_s_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              mode10_i,
  output logic              sda_pull_o,
  output logic              match_o,
  output logic              rd_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  addr_st_e          state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              second, more, rd_pend;
  logic              hit, need_more;

  always_comb begin
    if (second)        hit = (shreg == own_addr_i[BYTE_W-1:0]);
    else if (mode10_i) hit = (shreg[BYTE_W-1:3] == TEN_BIT_MARK) &&
                             (shreg[2:1] == own_addr_i[ADDR_W-1:BYTE_W]);
    else               hit = (shreg[BYTE_W-1:1] == own_addr_i[BYTE_W-2:0]);
    need_more = mode10_i & ~second;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      second     <= 1'b0;
      more       <= 1'b0;
      rd_pend    <= 1'b0;
      sda_pull_o <= 1'b0;
      match_o    <= 1'b0;
      rd_o       <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (start_det_i) begin
        state      <= ST_BYTE;
        cnt        <= '0;
        second     <= 1'b0;
        sda_pull_o <= 1'b0;
      end else if (stop_det_i) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_BYTE: begin
            if (scl_rise_i && cnt < CNT_FULL) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s_i};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == CNT_FULL) begin
              cnt <= '0;
              if (hit) begin
                sda_pull_o <= 1'b1;
                state      <= ST_ACK;
                more       <= need_more;
                if (!second) rd_pend <= shreg[0];
                if (!need_more) begin
                  match_o <= 1'b1;
                  rd_o    <= second ? rd_pend : shreg[0];
                end
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall_i) begin
              sda_pull_o <= 1'b0;
              if (more) begin
                state  <= ST_BYTE;
                second <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_addr.sv
module i2c_tgt_addr
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              mode10_i,
  output logic              sda_pull_o,
  output logic              match_o,
  output logic              rd_o,
  output logic              start_o,
  output logic              stop_o
);
  logic [1:0] sync_q;
  logic       scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;

  i2c_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (sync_q)
  );

  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  i2c_cond_det u_cond (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_s_i     (scl_s),
    .sda_s_i     (sda_s),
    .start_det_o (start_det),
    .stop_det_o  (stop_det),
    .scl_rise_o  (scl_rise),
    .scl_fall_o  (scl_fall),
    .start_o     (start_o),
    .stop_o      (stop_o)
  );

  i2c_addr_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_det_i (start_det),
    .stop_det_i  (stop_det),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_s_i     (sda_s),
    .own_addr_i  (own_addr_i),
    .mode10_i    (mode10_i),
    .sda_pull_o  (sda_pull_o),
    .match_o     (match_o),
    .rd_o        (rd_o)
  );
endmodule

// File: rtl/i2c_tgt_addr_chk.sv
module i2c_tgt_addr_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_pull_o,
  input logic match_o,
  input logic rd_o,
  input logic start_o,
  input logic stop_o
);
  // R1
  start_stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && stop_o));

  // R2
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !sda_pull_o);

  // R5
  pull_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_s);

  // R5
  pull_fall_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_o) |-> !scl_s);

  // R11
  match_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  // R11
  match_with_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> $rose(sda_pull_o));

  // R11
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_o) |-> match_o);
endmodule

bind i2c_tgt_addr i2c_tgt_addr_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .sda_pull_o (sda_pull_o),
  .match_o    (match_o),
  .rd_o       (rd_o),
  .start_o    (start_o),
  .stop_o     (stop_o)
);

// File: tb/i2c_tgt_addr_tb.sv
module i2c_tgt_addr_tb;
  localparam int Q = 16;
  localparam int NVEC = 9;
  // {mode10, own, byte1, byte2, ack1, ack2, match, rd}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 10'h052, 8'hA4, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
    {1'b0, 10'h052, 8'hA5, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1},
    {1'b0, 10'h052, 8'hA6, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h2B7, 8'hF4, 8'hB7, 1'b1, 1'b1, 1'b1, 1'b0},
    {1'b1, 10'h2B7, 8'hF5, 8'hB7, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b1, 10'h2B7, 8'hF4, 8'hB6, 1'b1, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h2B7, 8'hF2, 8'hB7, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b1, 10'h03D, 8'h7A, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {1'b0, 10'h079, 8'hF2, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [9:0] own = '0;
  logic mode10 = 1'b0;
  logic sda_pull, match, rd, start_p, stop_p, sda_bus;
  int checks = 0, fails = 0;
  int match_cnt = 0, start_cnt = 0, stop_cnt = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  i2c_tgt_addr u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_bus),
    .own_addr_i (own),
    .mode10_i   (mode10),
    .sda_pull_o (sda_pull),
    .match_o    (match),
    .rd_o       (rd),
    .start_o    (start_p),
    .stop_o     (stop_p)
  );

  always @(posedge clk) begin
    if (match)   match_cnt <= match_cnt + 1;
    if (start_p) start_cnt <= start_cnt + 1;
    if (stop_p)  stop_cnt  <= stop_cnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(1);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(1);
    scl_m = 1'b1; wq(2);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked, output logic released);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    acked = sda_pull;
    wq(1);
    scl_m = 1'b0; wq(1);
    released = ~sda_pull;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000 * 4 * Q / 4) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
    end
  end

  initial begin
    logic a1, a2, rel;
    logic exp_rd;
    int m0, s0, p0;
    exp_rd = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 pull", int'(sda_pull), 0);
    chk("R12 match", int'(match), 0);
    chk("R12 rd", int'(rd), 0);
    chk("R12 start/stop", int'(start_p | stop_p), 0);
    rst_n = 1'b1;
    wq(1);

    for (int v = 0; v < NVEC; v++) begin
      logic [30:0] e;
      e = VEC[v];
      mode10 = e[30];
      own = e[29:20];
      wq(1);
      m0 = match_cnt; s0 = start_cnt; p0 = stop_cnt;
      a2 = 1'b0;
      bus_start();
      chk("R1 start pulse", start_cnt - s0, 1);
      send_byte(e[19:12], a1, rel);
      // R3 R4 R6 R10 first byte acknowledge
      chk($sformatf("R3/R4/R6/R10 ack1 vec%0d", v), int'(a1), int'(e[3]));
      chk($sformatf("R5 release1 vec%0d", v), int'(rel), 1);
      if (e[30] && a1) begin
        send_byte(e[11:4], a2, rel);
        chk($sformatf("R7 ack2 vec%0d", v), int'(a2), int'(e[2]));
        chk($sformatf("R5 release2 vec%0d", v), int'(rel), 1);
      end
      bus_stop();
      chk($sformatf("R2 stop pulse vec%0d", v), stop_cnt - p0, 1);
      chk($sformatf("R6/R7/R11 match count vec%0d", v), match_cnt - m0, int'(e[1]));
      if (e[1]) exp_rd = e[0];
      chk($sformatf("R4/R7/R11 rd vec%0d", v), int'(rd), int'(exp_rd));
    end

    // R8 mismatch then matching byte without START
    mode10 = 1'b0; own = 10'h052; wq(1);
    m0 = match_cnt;
    bus_start();
    send_byte(8'hA6, a1, rel);
    chk("R8 mismatch no ack", int'(a1), 0);
    send_byte(8'hA4, a1, rel);
    chk("R8 ignored after mismatch", int'(a1), 0);
    bus_stop();
    chk("R8 no match", match_cnt - m0, 0);

    // R9 repeated START in the middle of a byte
    m0 = match_cnt; s0 = start_cnt;
    bus_start();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'hA5, a1, rel);
    chk("R9 ack after restart", int'(a1), 1);
    chk("R9 two starts", start_cnt - s0, 2);
    chk("R9 match", match_cnt - m0, 1);
    chk("R9 rd", int'(rd), 1);
    // R9 repeated START after a mismatch, write direction
    bus_start();
    send_byte(8'h12, a1, rel);
    chk("R9 mismatch before restart", int'(a1), 0);
    bus_start();
    send_byte(8'hA4, a1, rel);
    chk("R9 ack after restart from skip", int'(a1), 1);
    chk("R9 rd write", int'(rd), 0);
    bus_stop();

    done = 1'b1;
    summary();
  end
endmodule